// File: doc/BRIEF.md
# Bus Request/Grant Line Arbiter

This block decides, on the processor side, when an external bus master may take over the local bus. Each external master is attached through one shared request/grant line. On that line a master pulls low for one clock to ask for the bus. The arbiter answers on the same line with its own one-clock low pulse, and the master later pulls low for one clock again to hand the bus back. Each line is modelled as an output enable driven by the arbiter plus a sampled level. A line that nobody drives reads high.

The local bus cycle engine tells the arbiter the current bus phase. It also reports whether a locked instruction is running, whether the current transfer is the low half of a word, and whether the current transfer is the first half of an interrupt-acknowledge pair. The arbiter grants only at the points where the bus may be released. It raises `bus_float` for as long as the external master holds the bus, and it reports the owner. After each hand-back it keeps one idle clock free before the next grant. When both lines are ready at once, line 0 wins. A request that arrives while another master owns the bus is remembered and served later.

Top module: `rqgt_arbiter`

## Requirements
- R1: After a synchronous reset, `line_oe` is 0, `bus_float` is 0 and `bus_owner` is 0 (no owner).
- R2: A request pulse sampled in an idle clock (`bus_phase`=0) is answered with a grant (`line_oe[i]`=1) in the next clock if the phase is still idle. The grant lasts exactly one clock. From the clock after the grant, `bus_float`=1 and `bus_owner`=i+1.
- R3: Phase codes are 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4. A request sampled in an idle, T1 or T2 clock of a transfer is granted in that transfer's T4 clock.
- R4: A request first sampled in a T3, wait or T4 clock is not granted in that transfer's T4. It is granted at the next permitted point after a later idle, T1 or T2 clock has been seen.
- R5: No grant is given in a T4 clock while `word_low_half` or `inta_first` is 1. No grant is given at any point while `lock_active` is 1. A blocked request stays pending and is granted at the next permitted point.
- R6: A low pulse from the owning master while `bus_float`=1 ends the tenure. In the next clock `bus_float`=0 and `bus_owner`=0.
- R7: In the clock right after a release, no grant is given, even when a request is ready.
- R8: When both lines become ready in the same clock, line 0 is granted first. At most one line is granted per clock.
- R9: A request on the other line during a tenure is held. It is granted two clocks after the release clock, provided the phase is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_LINES | Sampled level of each request/grant line (0 = pulled low) |
| line_oe | output | NUM_LINES | Pull-low enable per line; 1 drives the grant pulse |
| bus_phase | input | 3 | Current bus phase code (0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4) |
| lock_active | input | 1 | Locked instruction in progress |
| word_low_half | input | 1 | Current transfer is the low half of a word |
| inta_first | input | 1 | Current transfer is the first interrupt-acknowledge pulse |
| bus_float | output | 1 | Processor must float the local bus |
| bus_owner | output | OWN_W | 0 none, i+1 when master on line i owns the bus |

## Verification
The hardest case to reach is a request that carries over to a later bus cycle. One path is a request that arrives too late in a transfer and has to be served in the next one. The other is a request from the second line that waits through a whole tenure of the first line and then through the mandatory idle clock. The bench reaches both with directed phase sequences. It steps the phase input through full transfers and places one-clock master pulses in chosen clocks. It then checks the line enables clock by clock across the gap after a release.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;

    typedef enum logic [2:0] {
        PH_TI = 3'd0,
        PH_T1 = 3'd1,
        PH_T2 = 3'd2,
        PH_T3 = 3'd3,
        PH_TW = 3'd4,
        PH_T4 = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        ARB_OPEN = 2'd0,
        ARB_HELD = 2'd1,
        ARB_GAP  = 2'd2
    } arb_state_e;

    // A request seen in one of these phases may still be served in this transfer's T4.
    function automatic logic phase_early(input logic [2:0] ph);
        return (ph == PH_TI) || (ph == PH_T1) || (ph == PH_T2);
    endfunction

    // Points where the bus may be handed over.
    function automatic logic release_point(input logic [2:0] ph, input logic lock,
                                           input logic word_low, input logic inta1);
        logic ok;
        ok = (ph == PH_TI) || ((ph == PH_T4) && !word_low && !inta1);
        return ok && !lock;
    endfunction

endpackage

// File: rtl/rqgt_line.sv
module rqgt_line (
    input  logic clk,
    input  logic rst,
    input  logic line_low,
    input  logic driving,
    input  logic owner_held,
    input  logic early,
    input  logic take,
    output logic pending,
    output logic ready
);
    logic new_req;

    // The own grant pulse and the owner's release pulse are not requests.
    assign new_req = line_low && !driving && !owner_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            ready   <= 1'b0;
        end else begin
            pending <= (pending || new_req) && !take;
            ready   <= (ready || ((pending || new_req) && early)) && !take;
        end
    end
endmodule

// File: rtl/rqgt_pick.sv
module rqgt_pick #(
    parameter int N  = 2,
    parameter int OW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [N-1:0]  ready,
    output logic [N-1:0]  grant,
    output logic [OW-1:0] code
);
    always_comb begin
        grant = '0;
        code  = '0;
        if (en) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (ready[i]) begin
                    grant    = '0;
                    grant[i] = 1'b1;
                    code     = OW'(i + 1);
                end
            end
        end
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R8
    grant_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ready[0]) |-> grant[0]);
endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
    import rqgt_pkg::*;
#(
    parameter int NUM_LINES = 2,
    localparam int OWN_W    = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] line_oe,
    input  logic [2:0]           bus_phase,
    input  logic                 lock_active,
    input  logic                 word_low_half,
    input  logic                 inta_first,
    output logic                 bus_float,
    output logic [OWN_W-1:0]     bus_owner
);
    arb_state_e           state_q, state_d;
    logic [OWN_W-1:0]     owner_q, owner_d;
    logic [NUM_LINES-1:0] ready, pending, owner_hot, pick_grant;
    logic [OWN_W-1:0]     pick_code;
    logic                 early, window, owner_release;

    assign early  = phase_early(bus_phase);
    assign window = (state_q == ARB_OPEN) &&
                    release_point(bus_phase, lock_active, word_low_half, inta_first);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign owner_hot[g] = (state_q == ARB_HELD) && (owner_q == OWN_W'(g + 1));
        rqgt_line u_line (
            .clk       (clk),
            .rst       (rst),
            .line_low  (!line_in[g]),
            .driving   (line_oe[g]),
            .owner_held(owner_hot[g]),
            .early     (early),
            .take      (pick_grant[g]),
            .pending   (pending[g]),
            .ready     (ready[g])
        );
    end

    rqgt_pick #(.N(NUM_LINES), .OW(OWN_W)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .en   (window),
        .ready(ready),
        .grant(pick_grant),
        .code (pick_code)
    );

    assign line_oe       = pick_grant;
    assign owner_release = |(owner_hot & ~line_in);

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ARB_OPEN: if (|pick_grant) begin
                state_d = ARB_HELD;
                owner_d = pick_code;
            end
            ARB_HELD: if (owner_release) begin
                state_d = ARB_GAP;
                owner_d = '0;
            end
            ARB_GAP:  state_d = ARB_OPEN;
            default:  state_d = ARB_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_OPEN;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    assign bus_float = (state_q == ARB_HELD);
    assign bus_owner = owner_q;

    // R2
    float_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (|line_oe) |=> bus_float);

    // R3
    grant_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (|line_oe) |-> (bus_phase == PH_TI || bus_phase == PH_T4));

    // R5
    lock_block_chk: assert property (@(posedge clk) disable iff (rst)
        lock_active |-> (line_oe == '0));

    // R5
    word_block_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_phase == PH_T4 && (word_low_half || inta_first)) |-> (line_oe == '0));

    // R7
    gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_float) |-> (line_oe == '0));

    // R6
    owner_float_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_owner != '0) == bus_float);
endmodule

// File: tb/rqgt_arbiter_test.sv
module rqgt_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] m_drv = 2'b00;
    logic [1:0] line_in, line_oe, bus_owner;
    logic [2:0] bus_phase = 3'd0;
    logic       lock_active = 1'b0, word_low_half = 1'b0, inta_first = 1'b0;
    logic       bus_float;
    int         nchk = 0, nerr = 0;

    always #2 clk = ~clk;

    assign line_in = ~(m_drv | line_oe);

    rqgt_arbiter uut (
        .clk(clk), .rst(rst), .line_in(line_in), .line_oe(line_oe),
        .bus_phase(bus_phase), .lock_active(lock_active),
        .word_low_half(word_low_half), .inta_first(inta_first),
        .bus_float(bus_float), .bus_owner(bus_owner)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs change 1 ns after the edge, checks follow 1 ns later.
    task automatic cyc(input logic [2:0] ph, input logic [1:0] drv,
                       input logic lk = 1'b0, input logic wl = 1'b0, input logic ia = 1'b0);
        @(posedge clk);
        #1;
        bus_phase = ph; m_drv = drv; lock_active = lk; word_low_half = wl; inta_first = ia;
        #1;
    endtask

    task automatic release_line(input int i);
        cyc(3'd0, 2'b01 << i);
        chk("R6 still floating in release clock", {7'd0, bus_float}, 8'd1);
        cyc(3'd0, 2'b00);
        chk("R6 float drops", {7'd0, bus_float}, 8'd0);
        chk("R6 owner cleared", {6'd0, bus_owner}, 8'd0);
        chk("R7 no grant in gap clock", {6'd0, line_oe}, 8'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        cyc(3'd0, 2'b00);
        cyc(3'd0, 2'b00);
        @(posedge clk); #1; rst = 1'b0; #1;
        chk("R1 line_oe", {6'd0, line_oe}, 8'd0);
        chk("R1 bus_float", {7'd0, bus_float}, 8'd0);
        chk("R1 bus_owner", {6'd0, bus_owner}, 8'd0);
    endtask

    task automatic t_idle_request;
        cyc(3'd0, 2'b01);
        chk("R2 no grant in request clock", {6'd0, line_oe}, 8'd0);
        cyc(3'd0, 2'b00);
        chk("R2 grant next clock", {6'd0, line_oe}, 8'h01);
        cyc(3'd0, 2'b00);
        chk("R2 grant one clock", {6'd0, line_oe}, 8'd0);
        chk("R2 float", {7'd0, bus_float}, 8'd1);
        chk("R2 owner", {6'd0, bus_owner}, 8'd1);
        release_line(0);
    endtask

    task automatic t_early_request;
        cyc(3'd1, 2'b10);
        cyc(3'd2, 2'b00);
        chk("R3 quiet T2", {6'd0, line_oe}, 8'd0);
        cyc(3'd3, 2'b00);
        chk("R3 quiet T3", {6'd0, line_oe}, 8'd0);
        cyc(3'd5, 2'b00);
        chk("R3 grant in T4", {6'd0, line_oe}, 8'h02);
        cyc(3'd0, 2'b00);
        chk("R3 owner line1", {6'd0, bus_owner}, 8'd2);
        release_line(1);
    endtask

    task automatic t_late_request;
        cyc(3'd3, 2'b01);
        cyc(3'd5, 2'b00);
        chk("R4 late request not granted in T4", {6'd0, line_oe}, 8'd0);
        cyc(3'd1, 2'b00);
        cyc(3'd2, 2'b00);
        cyc(3'd3, 2'b00);
        chk("R4 quiet T3", {6'd0, line_oe}, 8'd0);
        cyc(3'd5, 2'b00);
        chk("R4 granted next T4", {6'd0, line_oe}, 8'h01);
        cyc(3'd0, 2'b00);
        release_line(0);
    endtask

    task automatic t_blocked;
        // word low half
        cyc(3'd1, 2'b01);
        cyc(3'd2, 2'b00);
        cyc(3'd3, 2'b00);
        cyc(3'd5, 2'b00, 1'b0, 1'b1, 1'b0);
        chk("R5 word low half blocks T4", {6'd0, line_oe}, 8'd0);
        cyc(3'd1, 2'b00);
        cyc(3'd2, 2'b00);
        cyc(3'd3, 2'b00);
        cyc(3'd5, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R5 inta first blocks T4", {6'd0, line_oe}, 8'd0);
        cyc(3'd1, 2'b00);
        cyc(3'd2, 2'b00);
        cyc(3'd3, 2'b00);
        cyc(3'd5, 2'b00);
        chk("R5 pending served after block", {6'd0, line_oe}, 8'h01);
        cyc(3'd0, 2'b00);
        release_line(0);
        // lock
        cyc(3'd0, 2'b10, 1'b1);
        cyc(3'd0, 2'b00, 1'b1);
        chk("R5 lock blocks idle grant", {6'd0, line_oe}, 8'd0);
        cyc(3'd0, 2'b00, 1'b1);
        chk("R5 lock still blocks", {6'd0, line_oe}, 8'd0);
        cyc(3'd0, 2'b00, 1'b0);
        chk("R5 grant once lock drops", {6'd0, line_oe}, 8'h02);
        cyc(3'd0, 2'b00);
        release_line(1);
    endtask

    task automatic t_priority;
        cyc(3'd0, 2'b11);
        cyc(3'd0, 2'b00);
        chk("R8 line 0 wins", {6'd0, line_oe}, 8'h01);
        cyc(3'd0, 2'b00);
        chk("R8 owner line0", {6'd0, bus_owner}, 8'd1);
        release_line(0);
        cyc(3'd0, 2'b00);
        chk("R8 line 1 served after gap", {6'd0, line_oe}, 8'h02);
        cyc(3'd0, 2'b00);
        chk("R8 owner line1", {6'd0, bus_owner}, 8'd2);
        release_line(1);
    endtask

    task automatic t_tenure_request;
        cyc(3'd0, 2'b01);
        cyc(3'd0, 2'b00);
        chk("R9 first grant", {6'd0, line_oe}, 8'h01);
        cyc(3'd0, 2'b00);
        cyc(3'd0, 2'b10);
        chk("R9 no grant during tenure", {6'd0, line_oe}, 8'd0);
        chk("R9 owner kept", {6'd0, bus_owner}, 8'd1);
        cyc(3'd0, 2'b00);
        release_line(0);
        cyc(3'd0, 2'b00);
        chk("R9 held request granted", {6'd0, line_oe}, 8'h02);
        cyc(3'd0, 2'b00);
        chk("R9 owner line1", {6'd0, bus_owner}, 8'd2);
        release_line(1);
        cyc(3'd0, 2'b00);
        chk("R9 nothing left pending", {6'd0, line_oe}, 8'd0);
    endtask

    initial begin
        t_reset();
        t_idle_request();
        t_early_request();
        t_late_request();
        t_blocked();
        t_priority();
        t_tenure_request();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule